// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received Ethernet frames from a MAC byte stream into host memory. Software lays out a ring of four-word command descriptors in memory; each input descriptor names a buffer and a byte count. A no-op descriptor that branches back to the head closes the ring. The engine fetches a descriptor, packs the frame bytes little-endian into 32-bit words at the buffer address, and then writes a status word and the residual byte count back into the descriptor. It raises an interrupt pulse when the descriptor asks for one.

Software learns the received length as the descriptor count minus the written-back residual. It recycles a descriptor by clearing the status word. To hold the engine at a point in the ring, software rewrites a descriptor as a stop command. The engine parks there without touching the descriptor, and a continue command makes it fetch that same descriptor again. Start, continue, stop and reset arrive as single-cycle control pulses. The memory port is a plain word port with a fixed read latency of one cycle.

Top module: `rxring_dma`

## Requirements
- R1: After rst, or one cycle after a ctl_reset pulse, eng_run, eng_active, irq, rx_ready and mem_req are all 0 and the descriptor pointer is cleared.
- R2: A ctl_start pulse loads the pointer from ctl_cmd_ptr and sets eng_run and eng_active. The engine then reads the words at pointer, pointer+1 and pointer+2, and each read returns on mem_rdata in the cycle after the request. Descriptor word 0 is laid out as follows: bits [31:28] hold the opcode (2 input-last, 6 no-op, 7 stop), bits [25:24] the interrupt policy, bits [21:20] the branch policy (0 never, 3 always) and bits [15:0] the byte count. Word 1 holds the buffer word address, word 2 the branch target and word 3 the status and residual.
- R3: For an input-last descriptor, frame byte i is stored in lane i mod 4 (bits 8*(i mod 4)+7 down to 8*(i mod 4)) of word buffer+i/4. The lanes of the final word that receive no byte are written as zero, and words past the last stored byte are not written.
- R4: In the cycle after the frame's last byte is accepted, word 3 of the descriptor is written with status in bits [31:16] and the residual in bits [15:0]. Status bit 31 (active) is set, and the residual equals the count minus the frame length.
- R5: When a frame is longer than the count, only count bytes are stored and the excess bytes are still consumed. The residual is 0, status bit 16 (overflow) is set, and no word past the buffer is written.
- R6: irq is a single-cycle pulse that rises together with the status write when the interrupt policy is 3; it stays low when the policy is 0.
- R7: After an input-last descriptor completes, the engine fetches the next descriptor at pointer+4. A no-op descriptor with branch policy 3 moves the pointer to its word 2, which closes the ring.
- R8: A stop opcode, or any opcode other than 2 and 6, parks the engine with eng_active 0 and eng_run still 1. It writes no status and leaves rx_ready and mem_req at 0.
- R9: A ctl_continue pulse while eng_run is 1 and eng_active is 0 resumes fetching at the parked descriptor. While eng_run is 0 it has no effect.
- R10: A ctl_stop pulse clears eng_run and eng_active and abandons any frame in progress.
- R11: rx_ready is 1 only while the engine is waiting for or receiving frame bytes for an input-last descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Start pulse; loads the pointer |
| ctl_cmd_ptr | input | AW | Descriptor word address used by start |
| ctl_continue | input | 1 | Resume a parked engine |
| ctl_stop | input | 1 | Halt the engine and clear the run flag |
| ctl_reset | input | 1 | Software reset of flags and pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| irq | output | 1 | Completion interrupt pulse |
| eng_run | output | 1 | Run flag |
| eng_active | output | 1 | Engine is processing descriptors |

## Verification
Call the clock edge that accepts a frame's last byte edge P. The status write and the irq pulse are both due at edge P+1. At the falling edge after P, the bench confirms that the status word is still clear. At the next falling edge it compares the status word and records the cycle in which irq was seen, and it expects that cycle to be exactly one later. Buffer words are compared only after that point, once every byte write has landed. Control pulses and a parked engine are checked a few cycles after the pulse, when the fetch latency of three read cycles has passed.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int CNT_W      = 16;
    localparam int DESC_WORDS = 4;

    localparam logic [3:0] OPC_IN_LAST = 4'h2;
    localparam logic [3:0] OPC_NOP     = 4'h6;
    localparam logic [1:0] POL_ALWAYS  = 2'b11;

    typedef struct packed {
        logic [3:0]       op;
        logic [1:0]       rsv_a;
        logic [1:0]       irq_pol;
        logic [1:0]       rsv_b;
        logic [1:0]       br_pol;
        logic [3:0]       rsv_c;
        logic [CNT_W-1:0] count;
    } cmd_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_RD2,
        ST_DEC,
        ST_RX,
        ST_WB
    } eng_state_e;

    function automatic logic policy_fires(input logic [1:0] pol);
        return pol == POL_ALWAYS;
    endfunction

    function automatic logic [31:0] make_status(input logic ovf,
                                                input logic [CNT_W-1:0] resid);
        return {1'b1, 14'b0, ovf, resid};
    endfunction

endpackage

// File: rtl/rxring_packer.sv
module rxring_packer
    import rxring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic [CNT_W-1:0] load_count,
    input  logic             enable,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rx_ready,
    output logic             wr_req,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic             done,
    output logic [CNT_W-1:0] residual,
    output logic             overflow
);

    logic [CNT_W-1:0] left_q;
    logic [1:0]       lane_q;
    logic [31:0]      wbuf_q;
    logic [AW-1:0]    waddr_q;
    logic             ovf_q;
    logic [AW-1:0]    base_q;
    logic [CNT_W-1:0] cnt_q;

    logic        accept;
    logic        store;
    logic [31:0] merged;

    assign rx_ready = enable;
    assign accept   = enable && rx_valid;
    assign store    = accept && (left_q != '0);

    always_comb begin
        merged = wbuf_q;
        merged[{lane_q, 3'b000} +: 8] = rx_data;
    end

    assign wr_req   = store && (lane_q == 2'd3 || left_q == CNT_W'(1) || rx_last);
    assign wr_addr  = waddr_q;
    assign wr_data  = merged;
    assign done     = accept && rx_last;
    assign residual = left_q;
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            lane_q  <= '0;
            wbuf_q  <= '0;
            waddr_q <= '0;
            ovf_q   <= 1'b0;
            base_q  <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            left_q  <= load_count;
            lane_q  <= '0;
            wbuf_q  <= '0;
            waddr_q <= load_addr;
            ovf_q   <= 1'b0;
            base_q  <= load_addr;
            cnt_q   <= load_count;
        end else begin
            if (store) begin
                left_q <= left_q - CNT_W'(1);
                if (wr_req) begin
                    wbuf_q  <= '0;
                    lane_q  <= '0;
                    waddr_q <= waddr_q + AW'(1);
                end else begin
                    wbuf_q <= merged;
                    lane_q <= lane_q + 2'd1;
                end
            end
            if (accept && left_q == '0) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // R5, R3: every byte write stays inside the buffer the descriptor names
    assert_no_write_past_R5: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> ((32'(wr_addr - base_q) * 4) < 32'(cnt_q)));

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_start,
    input  logic [AW-1:0]    ctl_cmd_ptr,
    input  logic             ctl_continue,
    input  logic             ctl_stop,
    input  logic             ctl_reset,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             pk_load,
    output logic [AW-1:0]    pk_addr,
    output logic [CNT_W-1:0] pk_count,
    output logic             pk_enable,
    input  logic             pk_wr_req,
    input  logic [AW-1:0]    pk_wr_addr,
    input  logic [31:0]      pk_wr_data,
    input  logic             pk_done,
    input  logic [CNT_W-1:0] pk_residual,
    input  logic             pk_overflow,
    output logic             irq,
    output logic             eng_run,
    output logic             eng_active
);

    localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);

    eng_state_e    state_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] tgt_q;
    cmd_word_t     cmd_q;
    logic          run_q;
    logic          active_q;
    logic          irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            buf_q    <= '0;
            tgt_q    <= '0;
            cmd_q    <= '0;
            run_q    <= 1'b0;
            active_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctl_reset) begin
                state_q  <= ST_IDLE;
                run_q    <= 1'b0;
                active_q <= 1'b0;
                ptr_q    <= '0;
            end else if (ctl_stop) begin
                state_q  <= ST_IDLE;
                run_q    <= 1'b0;
                active_q <= 1'b0;
            end else if (ctl_start) begin
                ptr_q    <= ctl_cmd_ptr;
                run_q    <= 1'b1;
                active_q <= 1'b1;
                state_q  <= ST_RD0;
            end else if (ctl_continue && run_q && !active_q) begin
                active_q <= 1'b1;
                state_q  <= ST_RD0;
            end else begin
                case (state_q)
                    ST_RD0: state_q <= ST_RD1;
                    ST_RD1: begin
                        cmd_q   <= cmd_word_t'(mem_rdata);
                        state_q <= ST_RD2;
                    end
                    ST_RD2: begin
                        buf_q   <= mem_rdata[AW-1:0];
                        state_q <= ST_DEC;
                    end
                    ST_DEC: begin
                        tgt_q <= mem_rdata[AW-1:0];
                        case (cmd_q.op)
                            OPC_IN_LAST: state_q <= ST_RX;
                            OPC_NOP: begin
                                ptr_q   <= policy_fires(cmd_q.br_pol) ? mem_rdata[AW-1:0]
                                                                      : ptr_q + STEP;
                                irq_q   <= policy_fires(cmd_q.irq_pol);
                                state_q <= ST_RD0;
                            end
                            default: begin
                                irq_q    <= policy_fires(cmd_q.irq_pol);
                                active_q <= 1'b0;
                                state_q  <= ST_IDLE;
                            end
                        endcase
                    end
                    ST_RX: if (pk_done) state_q <= ST_WB;
                    ST_WB: begin
                        irq_q   <= policy_fires(cmd_q.irq_pol);
                        ptr_q   <= policy_fires(cmd_q.br_pol) ? tgt_q : ptr_q + STEP;
                        state_q <= ST_RD0;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        case (state_q)
            ST_RD0: mem_req = 1'b1;
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'(1);
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'(2);
            end
            ST_RX: begin
                mem_req   = pk_wr_req;
                mem_we    = pk_wr_req;
                mem_addr  = pk_wr_addr;
                mem_wdata = pk_wr_data;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + AW'(3);
                mem_wdata = make_status(pk_overflow, pk_residual);
            end
            default: ;
        endcase
    end

    assign pk_load    = (state_q == ST_DEC) && (cmd_q.op == OPC_IN_LAST);
    assign pk_addr    = buf_q;
    assign pk_count   = cmd_q.count;
    assign pk_enable  = (state_q == ST_RX);
    assign irq        = irq_q;
    assign eng_run    = run_q;
    assign eng_active = active_q;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |=> (!eng_run && !eng_active && !mem_req));

    assert_active_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
        eng_active |-> eng_run);

    assert_parked_no_bus_R8: assert property (@(posedge clk) disable iff (rst)
        !eng_active |-> !mem_req);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_ready_when_active_R11: assert property (@(posedge clk) disable iff (rst)
        pk_enable |-> eng_active);

    assert_continue_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_continue && !eng_run && !ctl_start && !ctl_reset && !ctl_stop) |=> !eng_active);

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
    import rxring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_start,
    input  logic [AW-1:0] ctl_cmd_ptr,
    input  logic          ctl_continue,
    input  logic          ctl_stop,
    input  logic          ctl_reset,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          irq,
    output logic          eng_run,
    output logic          eng_active
);

    logic             pk_load;
    logic [AW-1:0]    pk_addr;
    logic [CNT_W-1:0] pk_count;
    logic             pk_enable;
    logic             pk_wr_req;
    logic [AW-1:0]    pk_wr_addr;
    logic [31:0]      pk_wr_data;
    logic             pk_done;
    logic [CNT_W-1:0] pk_residual;
    logic             pk_overflow;

    rxring_ctrl #(.AW(AW)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .ctl_start    (ctl_start),
        .ctl_cmd_ptr  (ctl_cmd_ptr),
        .ctl_continue (ctl_continue),
        .ctl_stop     (ctl_stop),
        .ctl_reset    (ctl_reset),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .pk_load      (pk_load),
        .pk_addr      (pk_addr),
        .pk_count     (pk_count),
        .pk_enable    (pk_enable),
        .pk_wr_req    (pk_wr_req),
        .pk_wr_addr   (pk_wr_addr),
        .pk_wr_data   (pk_wr_data),
        .pk_done      (pk_done),
        .pk_residual  (pk_residual),
        .pk_overflow  (pk_overflow),
        .irq          (irq),
        .eng_run      (eng_run),
        .eng_active   (eng_active)
    );

    rxring_packer #(.AW(AW)) packer_i (
        .clk        (clk),
        .rst        (rst),
        .load       (pk_load),
        .load_addr  (pk_addr),
        .load_count (pk_count),
        .enable     (pk_enable),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_ready   (rx_ready),
        .wr_req     (pk_wr_req),
        .wr_addr    (pk_wr_addr),
        .wr_data    (pk_wr_data),
        .done       (pk_done),
        .residual   (pk_residual),
        .overflow   (pk_overflow)
    );

endmodule

// File: tb/rxring_dma_tb.sv
`timescale 1ns/1ps
module rxring_dma_tb_top;

    localparam int AW    = 12;
    localparam int RING  = 'h100;
    localparam int BUFS  = 'h200;
    localparam int BUFB  = 8;
    localparam int NDESC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_start = 1'b0;
    logic [AW-1:0] ctl_cmd_ptr = '0;
    logic          ctl_continue = 1'b0;
    logic          ctl_stop = 1'b0;
    logic          ctl_reset = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_last = 1'b0;
    logic          rx_ready, irq, eng_run, eng_active;

    logic [31:0] mem [0:(1<<AW)-1];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int irq_cnt  = 0;
    int irq_cyc  = -1;

    always #2.5 clk = ~clk;

    rxring_dma #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_cmd_ptr(ctl_cmd_ptr),
        .ctl_continue(ctl_continue), .ctl_stop(ctl_stop), .ctl_reset(ctl_reset),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .irq(irq), .eng_run(eng_run), .eng_active(eng_active)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (irq) begin
            irq_cnt <= irq_cnt + 1;
            irq_cyc <= cyc;
        end
    end

    function automatic logic [7:0] pat(int f, int i);
        return 8'(f * 29 + i * 7 + 3);
    endfunction

    function automatic logic [31:0] sent(int j);
        return 32'hC0DE_0000 + 32'(j);
    endfunction

    function automatic logic [31:0] exp_word(int f, int len, int j);
        int stored = (len < BUFB) ? len : BUFB;
        logic [31:0] w = '0;
        if (4 * j >= stored) return sent(j);
        for (int b = 0; b < 4; b++)
            if (4 * j + b < stored) w[8*b +: 8] = pat(f, 4 * j + b);
        return w;
    endfunction

    function automatic logic [31:0] exp_stat(int len);
        logic ovf = (len > BUFB);
        int   res = ovf ? 0 : BUFB - len;
        return {1'b1, 14'b0, ovf, 16'(res)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int dsc(int k);
        return RING + 4 * k;
    endfunction

    function automatic int bufa(int k);
        return BUFS + 4 * k;
    endfunction

    task automatic wr_desc(int k, logic [3:0] op, logic [1:0] ipol, logic [1:0] bpol);
        mem[dsc(k)]     <= {op, 2'b0, ipol, 2'b0, bpol, 4'b0, 16'(BUFB)};
        mem[dsc(k) + 1] <= 32'(bufa(k));
        mem[dsc(k) + 2] <= '0;
        mem[dsc(k) + 3] <= '0;
    endtask

    task automatic recycle(int k);
        mem[dsc(k) + 3] <= '0;
        for (int j = 0; j < 4; j++) mem[bufa(k) + j] <= sent(j);
    endtask

    task automatic send_frame(int f, int len);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = pat(f, i);
            rx_last  = (i == len - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic run_frame(int f, int k, int len, bit irq_on);
        int pre, n;
        recycle(k);
        @(negedge clk);
        pre = irq_cnt;
        send_frame(f, len);
        n = cyc;
        chk("R4 status not yet written", mem[dsc(k) + 3], 32'h0);
        @(negedge clk);
        chk("R4 status word", mem[dsc(k) + 3], exp_stat(len));
        @(negedge clk);
        if (irq_on) begin
            chk("R6 irq count", 32'(irq_cnt), 32'(pre + 1));
            chk("R6 irq cycle", 32'(irq_cyc), 32'(n + 1));
        end else begin
            chk("R6 irq suppressed", 32'(irq_cnt), 32'(pre));
        end
        for (int j = 0; j < 4; j++)
            chk(len > BUFB ? "R5 overflow buffer" : "R3 buffer word",
                mem[bufa(k) + j], exp_word(f, len, j));
    endtask

    task automatic pulse_start(int p);
        ctl_cmd_ptr = AW'(p);
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
    endtask

    task automatic pulse_continue();
        ctl_continue = 1'b1;
        @(negedge clk);
        ctl_continue = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int snap;
        for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
        for (int k = 0; k < NDESC; k++)
            wr_desc(k, 4'h2, (k == 2) ? 2'b00 : 2'b11, 2'b00);
        mem[dsc(NDESC)]     <= {4'h6, 2'b0, 2'b00, 2'b0, 2'b11, 4'b0, 16'h0};
        mem[dsc(NDESC) + 2] <= 32'(RING);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 run", {31'b0, eng_run}, 0);
        chk("R1 active", {31'b0, eng_active}, 0);
        chk("R1 ready", {31'b0, rx_ready}, 0);
        chk("R1 mem_req", {31'b0, mem_req}, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2: start loads pointer
        pulse_start(RING);
        chk("R2 run", {31'b0, eng_run}, 1);
        chk("R2 active", {31'b0, eng_active}, 1);
        repeat (5) @(negedge clk);
        chk("R11 ready waiting", {31'b0, rx_ready}, 1);

        // R3 R4 R5 R6 R7: sweep lengths across the ring and its wrap
        for (int f = 0; f < 12; f++)
            run_frame(f, f % NDESC, f + 1, (f % NDESC) != 2);

        // R8: descriptor turned into a stop, then R9 continue
        mem[dsc(1)]     <= {4'h7, 28'h0};
        mem[dsc(1) + 3] <= 32'h5A5A_5A5A;
        run_frame(12, 0, 5, 1'b1);
        snap = irq_cnt;
        repeat (6) @(negedge clk);
        chk("R8 parked active", {31'b0, eng_active}, 0);
        chk("R8 parked run", {31'b0, eng_run}, 1);
        chk("R8 parked ready", {31'b0, rx_ready}, 0);
        chk("R8 no status", mem[dsc(1) + 3], 32'h5A5A_5A5A);
        chk("R8 no irq", 32'(irq_cnt), 32'(snap));
        wr_desc(1, 4'h2, 2'b11, 2'b00);
        @(negedge clk);
        pulse_continue();
        repeat (5) @(negedge clk);
        chk("R9 resumed", {31'b0, eng_active}, 1);
        chk("R9 ready", {31'b0, rx_ready}, 1);
        run_frame(13, 1, 7, 1'b1);

        // R10: stop, R9: continue ignored while not running
        ctl_stop = 1'b1;
        @(negedge clk);
        ctl_stop = 1'b0;
        chk("R10 run", {31'b0, eng_run}, 0);
        chk("R10 active", {31'b0, eng_active}, 0);
        chk("R10 ready", {31'b0, rx_ready}, 0);
        pulse_continue();
        repeat (3) @(negedge clk);
        chk("R9 ignored active", {31'b0, eng_active}, 0);
        chk("R9 ignored bus", {31'b0, mem_req}, 0);

        // R1: software reset while running, then R2 start mid-ring
        pulse_start(RING);
        repeat (2) @(negedge clk);
        ctl_reset = 1'b1;
        @(negedge clk);
        ctl_reset = 1'b0;
        chk("R1 sw reset run", {31'b0, eng_run}, 0);
        chk("R1 sw reset active", {31'b0, eng_active}, 0);
        chk("R1 sw reset bus", {31'b0, mem_req}, 0);
        chk("R1 sw reset ready", {31'b0, rx_ready}, 0);
        pulse_start(dsc(3));
        run_frame(14, 3, BUFB, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule